// File: doc/BRIEF.md
# Periodic Interval Timer

The block is a memory-mapped tick source. A fixed divide-by-16 prescaler on the system clock advances a 20-bit interval counter. When the counter matches a programmable interval value, it returns to zero on the next prescaled tick. Each such wrap raises a sticky event flag and bumps a 12-bit saturating tally of wraps that have not yet been acknowledged. The flag, qualified by an interrupt enable, drives a level interrupt.

Software sees the count through two read views that return the same layout. The acknowledge view clears the flag and the tally as a side effect of the read. The snapshot view has no side effect and suits a free-running time base. When the enable is cleared, the counter does not stop at once. It runs on until its next wrap and then parks at zero, so software can poll for a zero count to learn that the timer has stopped.

Access is a single-cycle 32-bit register port. Read data is combinational from the current state. A read's side effect takes place on the clock edge that ends the access.

Top module: `pit_timer`

## Requirements
- R1: After reset every register, the prescaler, the counter and the tally are zero, `irq_o` is low, and every register reads as zero.
- R2: Register selection uses `addr_i[3:2]`: 0 is mode, 1 is status, 2 is the acknowledge view and 3 is the snapshot view. The mode register holds the interval value in bits [19:0], the run enable in bit 24 and the interrupt enable in bit 25, and reads back as written in those bits. All other mode bits read as zero.
- R3: While the counter is running it advances by one every 16 clock cycles. It runs when the run enable is 1 or the count is non-zero. The prescaler restarts from zero whenever the counter is idle.
- R4: A prescaled tick taken while the count equals the interval value returns the count to zero, so the period is the interval value plus one ticks. The same tick sets the status flag (status bit 0).
- R5: Each wrap adds one to the tally, which stops at 4095.
- R6: The acknowledge view and the snapshot view both return the tally in bits [31:20] and the count in bits [19:0]. A read of the acknowledge view clears the flag and the tally. If a wrap occurs on the same edge, that wrap is kept: the flag stays set and the tally becomes 1.
- R7: A read of the snapshot view leaves the flag and the tally unchanged.
- R8: Once the run enable is cleared, the counter goes on counting until its next wrap to zero and then holds at zero. Such a wrap still sets the flag and counts in the tally.
- R9: `irq_o` is high exactly when the flag is set and the interrupt enable is 1. The counter and the flag work the same with the interrupt enable at 0.
- R10: A new interval value written while the timer runs is used from the next comparison on, without resetting the count.
- R11: Writes to the status register, the acknowledge view and the snapshot view change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Register access in this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 4 | Byte offset; bits [3:2] select the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data; zero when no read is in progress |
| irq_o | output | 1 | Level interrupt request |

## Verification
The bench keeps a behavioural model of the count, tally and flag and compares the interrupt on every cycle and the read data on every read. It holds acknowledge reads for many consecutive cycles at an interval of zero, so that one read lands on a wrap edge. A design that let the acknowledge win would lose an event and show a cleared flag. It runs more than 4095 wraps with no acknowledge; a tally that wrapped instead of saturating would read back small. It clears the enable in the middle of a period and then checks that the count keeps advancing, wraps, and stays at zero. A design that stopped at once would freeze at a non-zero count, and one that never parked would leave the zero count. It also changes the interval value mid-run and issues snapshot reads between acknowledge reads. A design that reset the count on the write, or cleared state on a snapshot, would disagree with the model.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned CNT_W    = 20;
  localparam int unsigned TALLY_W  = 12;
  localparam int unsigned PRESC_W  = 4;
  localparam int unsigned EN_BIT   = 24;
  localparam int unsigned IEN_BIT  = 25;

  typedef enum logic [1:0] {
    REG_MODE  = 2'd0,
    REG_STAT  = 2'd1,
    REG_ACK   = 2'd2,
    REG_IMAGE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/pit_prescaler.sv
module pit_prescaler #(
  parameter int unsigned PRESC_W = pit_pkg::PRESC_W
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam logic [PRESC_W-1:0] LAST = {PRESC_W{1'b1}};

  logic [PRESC_W-1:0] div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     div_q <= '0;
    else if (run_i)  div_q <= div_q + 1'b1;
    else             div_q <= '0;
  end

  assign tick_o = run_i && (div_q == LAST);

  // R3: ticks are never back to back
  a_r3_tick_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
  // R3: idle counter means no tick on the following cycle
  a_r3_idle_no_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !tick_o);
endmodule

// File: rtl/pit_counter.sv
module pit_counter #(
  parameter int unsigned CNT_W   = pit_pkg::CNT_W,
  parameter int unsigned TALLY_W = pit_pkg::TALLY_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic [CNT_W-1:0]   piv_i,
  input  logic               ack_i,
  output logic [CNT_W-1:0]   cnt_o,
  output logic [TALLY_W-1:0] tally_o,
  output logic               status_o,
  output logic               wrap_o
);
  localparam logic [TALLY_W-1:0] TALLY_MAX = {TALLY_W{1'b1}};

  logic [CNT_W-1:0]   cnt_q;
  logic [TALLY_W-1:0] tally_q, tally_base;
  logic               status_q;

  assign wrap_o     = tick_i && (cnt_q == piv_i);
  assign tally_base = ack_i ? '0 : tally_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      tally_q  <= '0;
      status_q <= 1'b0;
    end else begin
      if (wrap_o)      cnt_q <= '0;
      else if (tick_i) cnt_q <= cnt_q + 1'b1;
      // a wrap on the acknowledge edge survives the acknowledge
      if (wrap_o && tally_base != TALLY_MAX) tally_q <= tally_base + 1'b1;
      else                                   tally_q <= tally_base;
      status_q <= wrap_o | (status_q & ~ack_i);
    end
  end

  assign cnt_o    = cnt_q;
  assign tally_o  = tally_q;
  assign status_o = status_q;

  a_r4_wrap_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> (cnt_q == '0) && status_q);
  a_r5_saturate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tally_q == TALLY_MAX) && !ack_i |=> tally_q == TALLY_MAX);
  a_r6_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i && !wrap_o |=> !status_q && (tally_q == '0));
  a_r6_ack_keeps_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i && wrap_o |=> status_q && (tally_q == 1));
  a_r3_no_tick_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_q));
endmodule

// File: rtl/pit_regs.sv
module pit_regs
  import pit_pkg::*;
#(
  parameter int unsigned CNT_W   = pit_pkg::CNT_W,
  parameter int unsigned TALLY_W = pit_pkg::TALLY_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sel_i,
  input  logic               we_i,
  input  logic [3:0]         addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [CNT_W-1:0]   cnt_i,
  input  logic [TALLY_W-1:0] tally_i,
  input  logic               status_i,
  output logic [CNT_W-1:0]   piv_o,
  output logic               en_o,
  output logic               ien_o,
  output logic               ack_o,
  output logic               img_rd_o,
  output logic [DATA_W-1:0]  rdata_o
);
  localparam int unsigned PAD_W = DATA_W - CNT_W - TALLY_W;

  reg_sel_e           rsel;
  logic               mode_wr, rd;
  logic [CNT_W-1:0]   piv_q;
  logic               en_q, ien_q;
  logic [DATA_W-1:0]  mode_view, stat_view, cnt_view, mux;

  assign rsel     = reg_sel_e'(addr_i[3:2]);
  assign rd       = sel_i && !we_i;
  assign mode_wr  = sel_i && we_i && (rsel == REG_MODE);
  assign ack_o    = rd && (rsel == REG_ACK);
  assign img_rd_o = rd && (rsel == REG_IMAGE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      piv_q <= '0;
      en_q  <= 1'b0;
      ien_q <= 1'b0;
    end else if (mode_wr) begin
      piv_q <= wdata_i[CNT_W-1:0];
      en_q  <= wdata_i[EN_BIT];
      ien_q <= wdata_i[IEN_BIT];
    end
  end

  always_comb begin
    mode_view          = '0;
    mode_view[CNT_W-1:0] = piv_q;
    mode_view[EN_BIT]  = en_q;
    mode_view[IEN_BIT] = ien_q;
  end

  assign stat_view = {{(DATA_W-1){1'b0}}, status_i};

  generate
    if (PAD_W > 0) begin : g_pad
      assign cnt_view = {{PAD_W{1'b0}}, tally_i, cnt_i};
    end else begin : g_nopad
      assign cnt_view = {tally_i, cnt_i};
    end
  endgenerate

  always_comb begin
    unique case (rsel)
      REG_MODE: mux = mode_view;
      REG_STAT: mux = stat_view;
      default:  mux = cnt_view;
    endcase
  end

  assign rdata_o = rd ? mux : '0;
  assign piv_o   = piv_q;
  assign en_o    = en_q;
  assign ien_o   = ien_q;

  a_r2_mode_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_wr |=> (piv_q == $past(wdata_i[CNT_W-1:0])) && (en_q == $past(wdata_i[EN_BIT])));
  a_r11_no_mode_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_wr |=> $stable(piv_q) && $stable(en_q) && $stable(ien_q));
  a_r2_one_view: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mode_wr, ack_o, img_rd_o}));
endmodule

// File: rtl/pit_timer.sv
module pit_timer
  import pit_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [3:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic [CNT_W-1:0]   piv, cnt;
  logic [TALLY_W-1:0] tally;
  logic               en, ien, ack, img_rd, status, wrap, tick, run;

  // keep running after disable until the count parks at zero
  assign run = en || (cnt != '0);

  pit_prescaler #(.PRESC_W(PRESC_W)) u_presc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run),
    .tick_o(tick)
  );

  pit_counter #(.CNT_W(CNT_W), .TALLY_W(TALLY_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick),
    .piv_i   (piv),
    .ack_i   (ack),
    .cnt_o   (cnt),
    .tally_o (tally),
    .status_o(status),
    .wrap_o  (wrap)
  );

  pit_regs #(.CNT_W(CNT_W), .TALLY_W(TALLY_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sel_i   (sel_i),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .cnt_i   (cnt),
    .tally_i (tally),
    .status_i(status),
    .piv_o   (piv),
    .en_o    (en),
    .ien_o   (ien),
    .ack_o   (ack),
    .img_rd_o(img_rd),
    .rdata_o (rdata_o)
  );

  assign irq_o = status && ien;

  a_r7_image_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    img_rd && !wrap |=> $stable(status) && $stable(tally));
  a_r8_park_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en && (cnt == '0) && !(sel_i && we_i) |=> cnt == '0);
  a_r9_irq_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ien |-> !irq_o);
endmodule

// File: tb/pit_timer_bench.sv
module pit_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_chk = 0, n_bad = 0;

  // reference model state
  int  m_presc = 0, m_cnt = 0, m_tally = 0, m_piv = 0;
  bit  m_st = 0, m_en = 0, m_ien = 0;

  always #5 clk = ~clk;

  pit_timer u_pit_timer (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  always @(posedge clk) begin
    if (rst_n) begin
      bit tick, wrp, ack, active;
      int t;
      active = m_en || (m_cnt != 0);
      tick = 0;
      if (active) begin
        if (m_presc == 15) begin tick = 1; m_presc = 0; end
        else m_presc = m_presc + 1;
      end else m_presc = 0;
      wrp = tick && (m_cnt == m_piv);
      ack = sel && !we && (addr[3:2] == 2'd2);
      if (wrp) m_cnt = 0;
      else if (tick) m_cnt = (m_cnt + 1) % (1 << 20);
      t = ack ? 0 : m_tally;
      if (wrp && t < 4095) t = t + 1;
      m_tally = t;
      m_st = wrp || (m_st && !ack);
      if (sel && we && addr[3:2] == 2'd0) begin
        m_piv = int'(wdata[19:0]);
        m_en  = wdata[24];
        m_ien = wdata[25];
      end
    end
  end

  function automatic logic [31:0] expect_rd(input logic [3:0] a);
    case (a[3:2])
      2'd0:    expect_rd = {6'b0, m_ien, m_en, 4'b0, m_piv[19:0]};
      2'd1:    expect_rd = {31'b0, m_st};
      default: expect_rd = {m_tally[11:0], m_cnt[19:0]};
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // R9: interrupt compared every cycle
  always @(negedge clk) begin
    if (rst_n) check("R9 irq", {31'b0, irq}, {31'b0, m_st && m_ien});
  end

  task automatic rd_burst(input logic [3:0] a, input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sel = 1'b1; we = 1'b0; addr = a;
      #1 check(tag, rdata, expect_rd(a));
    end
    @(negedge clk);
    sel = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] mode(input int piv, input bit en, input bit ien);
    return {6'b0, ien, en, 4'b0, piv[19:0]};
  endfunction

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    rd_burst(4'h0, 1, "R1 mode");
    rd_burst(4'h4, 1, "R1 status");
    rd_burst(4'h8, 1, "R1 value");
    rd_burst(4'hC, 1, "R1 image");
    check("R1 idle rdata", rdata, 32'h0);

    // R2 R3 R4: run, interrupt disabled
    wr(4'h0, mode(3, 1, 0));
    rd_burst(4'h0, 1, "R2 mode readback");
    wr(4'h0, 32'hFCFF_FFFF & mode(3, 1, 0) | 32'h0C00_0000 & 32'h0);
    for (int k = 0; k < 12; k++) begin
      idle(11);
      rd_burst(4'hC, 1, "R3 R4 count progress");
    end
    rd_burst(4'h4, 1, "R4 status set");
    // R9: enable interrupt
    wr(4'h0, mode(3, 1, 1));
    idle(5);
    // R6: acknowledge then R7 snapshots
    rd_burst(4'h8, 1, "R6 ack read");
    rd_burst(4'h4, 1, "R6 status after ack");
    rd_burst(4'hC, 20, "R7 snapshot");
    idle(80);
    rd_burst(4'hC, 3, "R7 snapshot tally");
    // R10: new interval while running
    wr(4'h0, mode(9, 1, 1));
    for (int k = 0; k < 15; k++) begin
      idle(13);
      rd_burst(4'hC, 1, "R10 count with new interval");
    end
    // R11: ignored writes
    wr(4'h4, 32'hFFFF_FFFF);
    wr(4'h8, 32'hFFFF_FFFF);
    wr(4'hC, 32'h0000_0000);
    rd_burst(4'h0, 1, "R11 mode unchanged");
    rd_burst(4'h4, 1, "R11 status unchanged");
    rd_burst(4'hC, 1, "R11 count unchanged");
    // R6: ack colliding with wrap at interval zero
    wr(4'h0, mode(0, 1, 1));
    rd_burst(4'h8, 40, "R6 ack vs wrap");
    rd_burst(4'h4, 1, "R6 status after burst");
    // R8: disable mid period
    wr(4'h0, mode(50, 1, 0));
    idle(300);
    wr(4'h0, mode(50, 0, 0));
    for (int k = 0; k < 60; k++) begin
      idle(14);
      rd_burst(4'hC, 1, "R8 run down");
    end
    rd_burst(4'h8, 1, "R8 parked");
    idle(100);
    rd_burst(4'hC, 1, "R8 still zero");
    // R5: saturation
    wr(4'h0, mode(0, 1, 0));
    idle(16 * 4100);
    rd_burst(4'hC, 1, "R5 tally saturated");
    rd_burst(4'h8, 1, "R5 ack saturated");
    rd_burst(4'hC, 1, "R5 tally after ack");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule